// File: doc/BRIEF.md
# Data-Acquisition Register Front End

This block is the byte-wide register front end of a multichannel analog-input card. A host bus with a 4-bit offset performs single-cycle writes and combinational reads. The block steers the analog multiplexer, chip selects and gain code. It starts conversions from a software strobe or a pacing tick, and it sequences a simple converter handshake. The handshake is a one-cycle start pulse, a fixed busy window, and then a capture of the converter's data word.

A 3-bit trigger code selects how conversions start and how completion is reported. Completion can be reported through a held interrupt request or a one-cycle DMA request. An active-low ready flag shows whether a fresh result is waiting. The block also holds the analog output words and sixteen digital outputs, and it returns sixteen digital input bits.

The conversion sequencer is a two-state machine. In `CV_IDLE` an accepted start moves it to `CV_BUSY` and emits `adc_start`. In `CV_BUSY` a down-counter runs for `CONV_CYCLES` cycles. The machine then returns to `CV_IDLE` on the completion cycle, which captures `adc_word`.

Top module: `daq_regfront`

## Requirements
- R1: After reset the trigger code is 0, every analog output word is 0, all digital outputs are 0, mux channel, chip selects and gain are 0, no interrupt or DMA request is active, and status offset 0x08 reads 0x20 (not ready).
- R2: The trigger code is control offset 0x0B bits 2:0. Code 0 and every code other than 1, 2 and 6 accept no start at all.
- R3: In code 1 a write of any data to offset 0x0C starts a conversion, and pacing ticks are ignored. In codes 2 and 6 a pacing tick starts a conversion, and a 0x0C write does not.
- R4: An accepted start gives a one-cycle `adc_start` pulse and a busy window of `CONV_CYCLES` cycles. A start that arrives during the busy window is ignored.
- R5: At the end of the busy window `adc_word` is captured as the result, and the ready flag turns active (0).
- R6: Offset 0x04 reads result bits 7:0. In the 12-bit build, offset 0x05 reads {000, not-ready, result bits 11:8}.
- R7: In the 16-bit build, offset 0x05 reads result bits 15:8. In both builds, status offset 0x08 reads bit 5 = not-ready, and its other bits are 0.
- R8: The ready flag returns to not-ready on an accepted start or on any write to 0x08. A completion in the same cycle wins.
- R9: In code 6 a completion raises an interrupt request that stays until any write to 0x08. With LINE_SELECT=1 only line ctrl bits 7:4 of `irq_lines` is driven. Otherwise only line DEFAULT_LINE is driven.
- R10: In code 2 a completion produces a single-cycle `dma_req` and no interrupt request.
- R11: Offset 0x0A bits 3:0 drive `mux_chan`, bit 4 drives `mux_cs[0]` and bit 5 drives `mux_cs[1]`. Offset 0x09 bits GAIN_W-1:0 drive `gain_code`.
- R12: Analog output k takes its low byte at 0x04+2k and its high nibble (data bits 3:0) at 0x05+2k. The output word changes only on the high-byte write.
- R13: Offsets 0x06 and 0x07 read `din` bits 7:0 and 15:8. Writes to 0x0D and 0x0E set `dout` bits 7:0 and 15:8.
- R14: With USE_EXT=0 the pacing source is `pace_tick`. With USE_EXT=1 it is `ext_trig`, and the other input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pace_tick | input | 1 | Internal pacer tick |
| ext_trig | input | 1 | External trigger pulse |
| adc_start | output | 1 | Conversion start pulse |
| adc_word | input | ADC_BITS | Converter result word |
| irq_lines | output | 16 | Interrupt request lines |
| dma_req | output | 1 | DMA request pulse |
| mux_chan | output | 4 | Multiplexer channel |
| mux_cs | output | 2 | Multiplexer chip selects |
| gain_code | output | GAIN_W | Gain select |
| ao_word | output | NUM_AO*AO_BITS | Analog output words, channel 0 in the low bits |
| din | input | 16 | Digital inputs |
| dout | output | 16 | Digital outputs |

## Verification
The bench builds two copies that share one bus. The first is a 12-bit build with line selection, internal pacing and CONV_CYCLES=5. The second is a 16-bit build with fixed line 5 and external pacing. With both copies, each ready-flag layout and both line-selection variants are reachable in one run. Driving only one pacing input at a time shows that each copy ignores the source it was not built for. A behavioural model predicts every output and the read data at each offset on every clock, including starts during the busy window and status writes.

// File: rtl/daq_pkg.sv
package daq_pkg;
    typedef enum logic [0:0] {CV_IDLE = 1'b0, CV_BUSY = 1'b1} conv_state_e;

    localparam logic [2:0] TRG_SOFT     = 3'd1;
    localparam logic [2:0] TRG_PACE_DMA = 3'd2;
    localparam logic [2:0] TRG_PACE_IRQ = 3'd6;

    localparam logic [3:0] OFS_DATA_LO = 4'h4;
    localparam logic [3:0] OFS_DATA_HI = 4'h5;
    localparam logic [3:0] OFS_DIN_LO  = 4'h6;
    localparam logic [3:0] OFS_DIN_HI  = 4'h7;
    localparam logic [3:0] OFS_STATUS  = 4'h8;
    localparam logic [3:0] OFS_GAIN    = 4'h9;
    localparam logic [3:0] OFS_MUX     = 4'hA;
    localparam logic [3:0] OFS_CTRL    = 4'hB;
    localparam logic [3:0] OFS_STROBE  = 4'hC;
    localparam logic [3:0] OFS_DOUT_LO = 4'hD;
    localparam logic [3:0] OFS_DOUT_HI = 4'hE;
endpackage

// File: rtl/daq_conv_fsm.sv
module daq_conv_fsm
    import daq_pkg::*;
#(
    parameter int ADC_BITS    = 12,
    parameter int CONV_CYCLES = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_req,
    input  logic                clr_ready,
    input  logic [ADC_BITS-1:0] adc_word,
    output logic                adc_start,
    output logic                done,
    output logic                ready,
    output logic [ADC_BITS-1:0] result
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);

    conv_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              accept;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CV_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CV_IDLE: begin
                if (start_req) begin
                    state_d = CV_BUSY;
                    cnt_d   = CNT_W'(CONV_CYCLES - 1);
                end
            end
            CV_BUSY: begin
                if (cnt_q == '0) state_d = CV_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = CV_IDLE;
        endcase
    end

    assign accept = (state_q == CV_IDLE) && start_req;
    assign done   = (state_q == CV_BUSY) && (cnt_q == '0);

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_start <= 1'b0;
            ready     <= 1'b0;
            result    <= '0;
        end else begin
            adc_start <= accept;
            if (done) begin
                result <= adc_word;
                ready  <= 1'b1;
            end else if (accept || clr_ready) begin
                ready  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/daq_req_gen.sv
module daq_req_gen
    import daq_pkg::*;
#(
    parameter int NUM_LINES    = 16,
    parameter bit LINE_SELECT  = 1'b1,
    parameter int DEFAULT_LINE = 0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         done,
    input  logic [2:0]                   mode,
    input  logic                         clr,
    input  logic [$clog2(NUM_LINES)-1:0] line_sel,
    output logic [NUM_LINES-1:0]         irq_lines,
    output logic                         dma_req
);
    logic irq_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pend <= 1'b0;
            dma_req  <= 1'b0;
        end else begin
            dma_req <= done && (mode == TRG_PACE_DMA);
            if (done && (mode == TRG_PACE_IRQ)) irq_pend <= 1'b1;
            else if (clr)                       irq_pend <= 1'b0;
        end
    end

    generate
        if (LINE_SELECT) begin : g_sel
            assign irq_lines = irq_pend ? (NUM_LINES'(1) << line_sel) : '0;
        end else begin : g_fixed
            logic [$clog2(NUM_LINES)-1:0] unused_sel;
            assign unused_sel = line_sel;
            assign irq_lines  = irq_pend ? (NUM_LINES'(1) << DEFAULT_LINE) : '0;
        end
    endgenerate
endmodule

// File: rtl/daq_ao_chan.sv
module daq_ao_chan #(
    parameter int AO_BITS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [7:0]         wdata,
    output logic [AO_BITS-1:0] ao
);
    logic [7:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            ao     <= '0;
        end else begin
            if (wr_lo) hold_q <= wdata;
            if (wr_hi) ao     <= {wdata[AO_BITS-9:0], hold_q};
        end
    end
endmodule

// File: rtl/daq_regfront.sv
module daq_regfront
    import daq_pkg::*;
#(
    parameter int ADC_BITS     = 12,
    parameter int CONV_CYCLES  = 5,
    parameter int NUM_AO       = 2,
    parameter int AO_BITS      = 12,
    parameter int GAIN_W       = 4,
    parameter bit LINE_SELECT  = 1'b1,
    parameter int DEFAULT_LINE = 0,
    parameter bit USE_EXT      = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [3:0]                bus_addr,
    input  logic [7:0]                bus_wdata,
    output logic [7:0]                bus_rdata,
    input  logic                      pace_tick,
    input  logic                      ext_trig,
    output logic                      adc_start,
    input  logic [ADC_BITS-1:0]       adc_word,
    output logic [15:0]               irq_lines,
    output logic                      dma_req,
    output logic [3:0]                mux_chan,
    output logic [1:0]                mux_cs,
    output logic [GAIN_W-1:0]         gain_code,
    output logic [NUM_AO*AO_BITS-1:0] ao_word,
    input  logic [15:0]               din,
    output logic [15:0]               dout
);
    localparam int NUM_LINES = 16;

    logic [2:0]          mode_q;
    logic [3:0]          line_q;
    logic [5:0]          mux_q;
    logic [GAIN_W-1:0]   gain_q;
    logic [15:0]         dout_q;
    logic                tick;
    logic                strobe_hit, clr_hit, start_req;
    logic                conv_done, conv_ready;
    logic [ADC_BITS-1:0] conv_result;
    logic [7:0]          data_hi, status_byte;

    // pacing source
    generate
        if (USE_EXT) begin : g_ext
            logic unused_tick;
            assign unused_tick = pace_tick;
            assign tick        = ext_trig;
        end else begin : g_int
            logic unused_tick;
            assign unused_tick = ext_trig;
            assign tick        = pace_tick;
        end
    endgenerate

    assign strobe_hit = bus_wr && (bus_addr == OFS_STROBE);
    assign clr_hit    = bus_wr && (bus_addr == OFS_STATUS);
    assign start_req  = ((mode_q == TRG_SOFT) && strobe_hit) ||
                        (((mode_q == TRG_PACE_DMA) || (mode_q == TRG_PACE_IRQ)) && tick);

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            line_q <= '0;
            mux_q  <= '0;
            gain_q <= '0;
            dout_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL:    begin mode_q <= bus_wdata[2:0]; line_q <= bus_wdata[7:4]; end
                OFS_MUX:     mux_q        <= bus_wdata[5:0];
                OFS_GAIN:    gain_q       <= bus_wdata[GAIN_W-1:0];
                OFS_DOUT_LO: dout_q[7:0]  <= bus_wdata;
                OFS_DOUT_HI: dout_q[15:8] <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign mux_chan  = mux_q[3:0];
    assign mux_cs    = mux_q[5:4];
    assign gain_code = gain_q;
    assign dout      = dout_q;

    daq_conv_fsm #(.ADC_BITS(ADC_BITS), .CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .clr_ready (clr_hit),
        .adc_word  (adc_word),
        .adc_start (adc_start),
        .done      (conv_done),
        .ready     (conv_ready),
        .result    (conv_result)
    );

    daq_req_gen #(.NUM_LINES(NUM_LINES), .LINE_SELECT(LINE_SELECT),
                  .DEFAULT_LINE(DEFAULT_LINE)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (conv_done),
        .mode      (mode_q),
        .clr       (clr_hit),
        .line_sel  (line_q),
        .irq_lines (irq_lines),
        .dma_req   (dma_req)
    );

    // analog output channels
    generate
        for (genvar k = 0; k < NUM_AO; k++) begin : g_ao
            logic wr_lo, wr_hi;
            assign wr_lo = bus_wr && (bus_addr == 4'(4 + 2 * k));
            assign wr_hi = bus_wr && (bus_addr == 4'(5 + 2 * k));
            daq_ao_chan #(.AO_BITS(AO_BITS)) u_ao (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_lo (wr_lo),
                .wr_hi (wr_hi),
                .wdata (bus_wdata),
                .ao    (ao_word[k*AO_BITS +: AO_BITS])
            );
        end
    endgenerate

    // result high byte layout depends on converter width
    generate
        if (ADC_BITS > 12) begin : g_wide
            assign data_hi = 8'(conv_result >> 8);
        end else begin : g_narrow
            assign data_hi = {3'b000, ~conv_ready, 4'(conv_result >> 8)};
        end
    endgenerate

    assign status_byte = {2'b00, ~conv_ready, 5'b00000};

    always_comb begin
        case (bus_addr)
            OFS_DATA_LO: bus_rdata = conv_result[7:0];
            OFS_DATA_HI: bus_rdata = data_hi;
            OFS_DIN_LO:  bus_rdata = din[7:0];
            OFS_DIN_HI:  bus_rdata = din[15:8];
            OFS_STATUS:  bus_rdata = status_byte;
            default:     bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/daq_regfront_chk.sv
module daq_regfront_chk #(
    parameter int AO_W = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic [3:0]      bus_addr,
    input logic [2:0]      mode,
    input logic            adc_start,
    input logic            done,
    input logic            ready,
    input logic            dma_req,
    input logic [15:0]     irq_lines,
    input logic [AO_W-1:0] ao_word
);
    p_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> ($past(mode) == 3'd1 || $past(mode) == 3'd2 || $past(mode) == 3'd6));

    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    p_ready_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);

    p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> !ready);

    p_status_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'h8 && !done) |=> (irq_lines == 16'h0000));

    p_one_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_lines));

    p_dma_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> ($past(mode) == 3'd2));

    p_ao_lo_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'h4) |=> $stable(ao_word));
endmodule

bind daq_regfront daq_regfront_chk #(.AO_W(NUM_AO*AO_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .mode      (mode_q),
    .adc_start (adc_start),
    .done      (conv_done),
    .ready     (conv_ready),
    .dma_req   (dma_req),
    .irq_lines (irq_lines),
    .ao_word   (ao_word)
);

// File: tb/daq_regfront_tb_top.sv
module daq_regfront_tb_top;
    localparam int CONV = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        pace_tick = 1'b0;
    logic        ext_trig = 1'b0;
    logic [15:0] adc_val = '0;
    logic [15:0] din = '0;

    logic [7:0]  rd [2];
    logic        st [2];
    logic [15:0] irq [2];
    logic        dma [2];
    logic [3:0]  chan [2];
    logic [1:0]  cs [2];
    logic [3:0]  gain [2];
    logic [23:0] ao [2];
    logic [15:0] dout [2];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int st_cnt [2];
    int dma_cnt [2];

    always #5 clk = ~clk;

    daq_regfront #(.ADC_BITS(12), .CONV_CYCLES(CONV), .LINE_SELECT(1'b1), .USE_EXT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd[0]), .pace_tick(pace_tick), .ext_trig(ext_trig), .adc_start(st[0]),
        .adc_word(adc_val[11:0]), .irq_lines(irq[0]), .dma_req(dma[0]), .mux_chan(chan[0]),
        .mux_cs(cs[0]), .gain_code(gain[0]), .ao_word(ao[0]), .din(din), .dout(dout[0]));

    daq_regfront #(.ADC_BITS(16), .CONV_CYCLES(CONV), .LINE_SELECT(1'b0), .DEFAULT_LINE(5),
                   .USE_EXT(1'b1)) dut16_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd[1]), .pace_tick(pace_tick), .ext_trig(ext_trig), .adc_start(st[1]),
        .adc_word(adc_val), .irq_lines(irq[1]), .dma_req(dma[1]), .mux_chan(chan[1]),
        .mux_cs(cs[1]), .gain_code(gain[1]), .ao_word(ao[1]), .din(din), .dout(dout[1]));

    // behavioural reference state
    int          m_busy [2];
    bit          m_ready [2];
    bit          m_irq [2];
    bit          m_dma [2];
    bit          m_st [2];
    logic [15:0] m_data [2];
    logic [7:0]  m_ctrl, m_mux, m_gain;
    logic [7:0]  m_hold [2];
    logic [11:0] m_ao [2];
    logic [15:0] m_dout;

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd(input int i, input logic [3:0] a);
        case (a)
            4'h4: return m_data[i][7:0];
            4'h5: return (i == 1) ? m_data[i][15:8] : {3'b000, ~m_ready[i], m_data[i][11:8]};
            4'h6: return din[7:0];
            4'h7: return din[15:8];
            4'h8: return {2'b00, ~m_ready[i], 5'b00000};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(input int i, input logic [3:0] a);
        if (a == 4'h5 && i == 1) return "R7";
        if (a == 4'h6 || a == 4'h7) return "R13";
        if (a == 4'h8) return "R8";
        return "R6";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_busy[i] = 0; m_ready[i] = 0; m_irq[i] = 0; m_dma[i] = 0; m_st[i] = 0;
                m_data[i] = '0; m_hold[i] = '0; m_ao[i] = '0;
            end
            m_ctrl = '0; m_mux = '0; m_gain = '0; m_dout = '0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                logic [2:0] mode;
                bit tk, start, clr, done;
                mode  = m_ctrl[2:0];
                tk    = (i == 1) ? ext_trig : pace_tick;
                start = (mode == 3'd1 && bus_wr && bus_addr == 4'hC) ||
                        ((mode == 3'd2 || mode == 3'd6) && tk);
                clr   = bus_wr && bus_addr == 4'h8;
                done  = (m_busy[i] == 1);
                m_st[i]  = 0;
                m_dma[i] = 0;
                if (m_busy[i] > 0) m_busy[i]--;
                else if (start) begin m_busy[i] = CONV; m_st[i] = 1; end
                if (done) begin
                    m_data[i]  = (i == 1) ? adc_val : {4'h0, adc_val[11:0]};
                    m_ready[i] = 1;
                    m_dma[i]   = (mode == 3'd2);
                end else if (m_st[i] || clr) m_ready[i] = 0;
                if (done && mode == 3'd6) m_irq[i] = 1;
                else if (clr)             m_irq[i] = 0;
            end
            if (bus_wr) begin
                case (bus_addr)
                    4'h4: m_hold[0] = bus_wdata;
                    4'h5: m_ao[0] = {bus_wdata[3:0], m_hold[0]};
                    4'h6: m_hold[1] = bus_wdata;
                    4'h7: m_ao[1] = {bus_wdata[3:0], m_hold[1]};
                    4'h9: m_gain = {4'h0, bus_wdata[3:0]};
                    4'hA: m_mux = {2'b00, bus_wdata[5:0]};
                    4'hB: m_ctrl = bus_wdata;
                    4'hD: m_dout[7:0] = bus_wdata;
                    4'hE: m_dout[15:8] = bus_wdata;
                    default: ;
                endcase
            end
        end
        #2;
        for (int i = 0; i < 2; i++) begin
            logic [15:0] exp_irq;
            if (st[i]) st_cnt[i]++;
            if (dma[i]) dma_cnt[i]++;
            exp_irq = !m_irq[i] ? 16'h0 : (i == 0) ? (16'h1 << m_ctrl[7:4]) : 16'h0020;
            chk(rd_tag(i, bus_addr), "rdata", rd[i], exp_rd(i, bus_addr));
            chk("R4", "adc_start", st[i], m_st[i]);
            chk("R9", "irq_lines", irq[i], exp_irq);
            chk("R10", "dma_req", dma[i], m_dma[i]);
            chk("R11", "mux", {cs[i], chan[i]}, m_mux[5:0]);
            chk("R11", "gain", gain[i], m_gain[3:0]);
            chk("R12", "ao_word", ao[i], {m_ao[1], m_ao[0]});
            chk("R13", "dout", dout[i], m_dout);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] e0,
                          input logic [7:0] e1);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk);
        #3;
        chk(tag, "read dut12", rd[0], e0);
        chk(tag, "read dut16", rd[1], e1);
    endtask

    task automatic pulse(input bit p, input bit e);
        @(negedge clk);
        pace_tick = p; ext_trig = e;
        @(negedge clk);
        pace_tick = 1'b0; ext_trig = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        int s0, s1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #3;
        // R1 reset state
        for (int i = 0; i < 2; i++) begin
            chk("R1", "ao reset", ao[i], 24'h0);
            chk("R1", "dout reset", dout[i], 16'h0);
            chk("R1", "irq reset", irq[i], 16'h0);
            chk("R1", "dma reset", dma[i], 1'b0);
            chk("R1", "mux/gain reset", {cs[i], chan[i], gain[i]}, 10'h0);
        end
        rd_chk("R1", 4'h8, 8'h20, 8'h20);

        // R2 code 0: nothing starts
        wr(4'hC, 8'h77);
        pulse(1'b1, 1'b1);
        idle(CONV + 3);
        rd_chk("R2", 4'h8, 8'h20, 8'h20);
        chk("R2", "no start in code 0", st_cnt[0] + st_cnt[1], 0);

        // R3/R4/R5 software start, second strobe while busy is ignored
        wr(4'hB, 8'h31);
        adc_val = 16'hABCD;
        s0 = st_cnt[0]; s1 = st_cnt[1];
        wr(4'hC, 8'h00);
        wr(4'hC, 8'hFF);
        idle(CONV + 2);
        chk("R4", "one start dut12", st_cnt[0] - s0, 1);
        chk("R4", "one start dut16", st_cnt[1] - s1, 1);
        rd_chk("R5", 4'h4, 8'hCD, 8'hCD);
        rd_chk("R6", 4'h5, 8'h0B, 8'hAB);
        rd_chk("R7", 4'h8, 8'h00, 8'h00);

        // R3 pacing ignored in software code
        pulse(1'b1, 1'b1);
        idle(CONV + 2);
        rd_chk("R3", 4'h8, 8'h00, 8'h00);

        // R8 status write clears ready
        wr(4'h8, 8'h5A);
        rd_chk("R8", 4'h8, 8'h20, 8'h20);

        // R2 unused code 7
        wr(4'hB, 8'h37);
        pulse(1'b1, 1'b1);
        wr(4'hC, 8'h01);
        idle(CONV + 2);
        rd_chk("R2", 4'h8, 8'h20, 8'h20);

        // R9/R14 interrupt mode, separate pacing sources
        wr(4'hB, 8'h36);
        adc_val = 16'h1357;
        pulse(1'b1, 1'b0);
        idle(CONV + 2);
        chk("R9", "irq line 3", irq[0], 16'h0008);
        chk("R14", "dut16 ignores pace_tick", irq[1], 16'h0000);
        pulse(1'b0, 1'b1);
        idle(CONV + 2);
        chk("R14", "dut16 line 5", irq[1], 16'h0020);
        chk("R14", "dut12 ignores ext_trig", irq[0], 16'h0008);
        rd_chk("R7", 4'h5, 8'h03, 8'h13);
        wr(4'h8, 8'h00);
        chk("R9", "irq cleared dut12", irq[0], 16'h0);
        chk("R9", "irq cleared dut16", irq[1], 16'h0);

        // R10 DMA mode
        wr(4'hB, 8'h02);
        s0 = dma_cnt[0]; s1 = dma_cnt[1];
        pulse(1'b1, 1'b1);
        idle(CONV + 3);
        chk("R10", "dma pulses dut12", dma_cnt[0] - s0, 1);
        chk("R10", "dma pulses dut16", dma_cnt[1] - s1, 1);
        chk("R10", "no irq in dma mode", irq[0] | irq[1], 16'h0);

        // R11 mux and gain
        wr(4'hA, 8'h1B);
        chk("R11", "chan/cs", {cs[0], chan[0]}, 6'h1B);
        wr(4'hA, 8'h35);
        chk("R11", "chan/cs both", {cs[1], chan[1]}, 6'h35);
        wr(4'h9, 8'hF7);
        chk("R11", "gain", gain[0], 4'h7);

        // R12 analog outputs
        wr(4'h4, 8'h34);
        chk("R12", "low byte holds", ao[0], 24'h0);
        wr(4'h5, 8'hF2);
        chk("R12", "ch0 update", ao[0][11:0], 12'h234);
        wr(4'h6, 8'h99);
        wr(4'h7, 8'h01);
        chk("R12", "both channels", ao[1], 24'h199234);

        // R13 digital I/O
        wr(4'hD, 8'hA5);
        wr(4'hE, 8'h3C);
        chk("R13", "dout", dout[0], 16'h3CA5);
        din = 16'h1234;
        rd_chk("R13", 4'h6, 8'h34, 8'h34);
        rd_chk("R13", 4'h7, 8'h12, 8'h12);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end
endmodule